// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block makes a slow clock, for example close to 32.768 kHz, from a fast reference clock. A single integer ratio rarely matches the target. The block therefore alternates between two integer ratios. It holds the first ratio for a programmed number of output periods, then holds the second ratio for another programmed number, and repeats. The average ratio is then a fraction that lies between the two integers.

Two 32-bit control words are loaded through a write-only port. They hold the two ratios, the two repeat counts, a dual-mode enable, a bypass, and separate input and output gate enables. The divided result comes out as a registered square wave on `clk_o` and as a one-cycle pulse on `tick_o` at the end of every output period. To reprogram the block, software closes both gates and writes the new settings. It then opens the input gate, and opens the output gate only after the divider has settled. The output gate opens and closes only while the wave is low, so no shortened pulse reaches the output.

Top module: `frac_clk_div`

## Requirements
- R1: After reset both control words are zero, `clk_o` and `tick_o` are low, and no tick appears until the settings are written.
- R2: A write with `wr_addr_i`=0 loads control word A. Bits [11:0] hold the first ratio minus one. Bits [23:12] hold the second ratio minus one. Bit 28 enables dual mode, bit 30 enables the output gate and bit 31 enables the input gate.
- R3: A write with `wr_addr_i`=1 loads control word B. Bits [11:0] hold the first repeat count minus one. Bits [23:12] hold the second repeat count minus one. Bit 24 enables bypass.
- R4: With dual mode off, every output period lasts (first ratio field + 1) reference cycles. The second ratio and both repeat counts have no effect.
- R5: With dual mode on, the block produces (first count field + 1) periods of the first ratio, then (second count field + 1) periods of the second ratio, and repeats. The reference cycles in one full pattern add up to the sum of each count times its ratio; for fields 732/731/7/10 this sum is 13916.
- R6: Each output period of ratio r is high for floor(r/2) reference cycles and low for the rest of the period.
- R7: While the input gate is closed, the divider is held at the start of a first-ratio period and `tick_o` stays low. After the gate reopens, the sequence restarts with the first ratio.
- R8: While the output gate is closed, `clk_o` and `tick_o` stay low even though the divider runs. The gate changes state only during a low phase, so the first high pulse after opening has its full length.
- R9: With bypass on and both gates open, `clk_o` follows the reference clock and `tick_o` is high on every cycle, whatever the ratio fields hold. If either gate is closed, `clk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control words |
| wr_addr_i | input | 1 | Selects control word A (0) or B (1) |
| wr_data_i | input | 32 | Write data |
| clk_o | output | 1 | Divided clock, or the reference clock in bypass |
| tick_o | output | 1 | One-cycle pulse at the end of each output period |

## Verification
A write takes effect at the clock edge that samples the strobe. `clk_o` and `tick_o` are registered, so each follows the divider state one edge later. The scoreboard compares the intervals between consecutive `tick_o` pulses, so this fixed latency cancels out. The first pulse after arming only sets the starting point, and the queue holds the expected periods from the second period of the pattern onward. Duty, gating and reset checks sample at the falling edge of the clock, when the outputs are stable. Bypass checks sample a quarter period into the high half and into the low half of the reference clock, because that path follows the clock itself within the same cycle.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FLD_LO    = 0;
  localparam int unsigned FLD_HI    = 12;
  localparam int unsigned BIT_DUAL  = 28;
  localparam int unsigned BIT_OGATE = 30;
  localparam int unsigned BIT_IGATE = 31;
  localparam int unsigned BIT_BYP   = 24;

  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
  import frac_div_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  ratio_a_o,
  output logic [DIV_W-1:0]  ratio_b_o,
  output logic [DIV_W-1:0]  reps_a_o,
  output logic [DIV_W-1:0]  reps_b_o,
  output logic              dual_o,
  output logic              ogate_o,
  output logic              igate_o,
  output logic              byp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_a_o <= '0;
      ratio_b_o <= '0;
      dual_o    <= 1'b0;
      ogate_o   <= 1'b0;
      igate_o   <= 1'b0;
    end else if (wr_en_i && !wr_addr_i) begin
      ratio_a_o <= wr_data_i[FLD_LO +: DIV_W];
      ratio_b_o <= wr_data_i[FLD_HI +: DIV_W];
      dual_o    <= wr_data_i[BIT_DUAL];
      ogate_o   <= wr_data_i[BIT_OGATE];
      igate_o   <= wr_data_i[BIT_IGATE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reps_a_o <= '0;
      reps_b_o <= '0;
      byp_o    <= 1'b0;
    end else if (wr_en_i && wr_addr_i) begin
      reps_a_o <= wr_data_i[FLD_LO +: DIV_W];
      reps_b_o <= wr_data_i[FLD_HI +: DIV_W];
      byp_o    <= wr_data_i[BIT_BYP];
    end
  end
endmodule

// File: rtl/frac_div_core.sv
module frac_div_core
  import frac_div_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_a_i,
  input  logic [DIV_W-1:0] ratio_b_i,
  input  logic [DIV_W-1:0] reps_a_i,
  input  logic [DIV_W-1:0] reps_b_i,
  input  logic             dual_i,
  input  logic             igate_i,
  input  logic             byp_i,
  output logic             hi_d_o,
  output logic             per_end_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] cur_ratio_o,
  output logic             ph_b_o
);
  localparam int unsigned HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, rep_q, cur_ratio, cur_reps;
  logic [HW-1:0]    half;
  phase_e           ph_q;
  logic             run;

  assign run       = igate_i & ~byp_i;
  assign cur_ratio = (ph_q == PH_B) ? ratio_b_i : ratio_a_i;
  assign cur_reps  = (ph_q == PH_B) ? reps_b_i  : reps_a_i;
  // ratio = field+1; high phase is floor(ratio/2)
  assign half      = ({1'b0, cur_ratio} + HW'(1)) >> 1;
  assign per_end_o = run & (cnt_q >= cur_ratio);
  assign hi_d_o    = run & ({1'b0, cnt_q} < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rep_q <= '0;
      ph_q  <= PH_A;
    end else if (!run) begin
      cnt_q <= '0;
      rep_q <= '0;
      ph_q  <= PH_A;
    end else if (per_end_o) begin
      cnt_q <= '0;
      if (!dual_i) begin
        rep_q <= '0;
        ph_q  <= PH_A;
      end else if (rep_q >= cur_reps) begin
        rep_q <= '0;
        ph_q  <= (ph_q == PH_A) ? PH_B : PH_A;
      end else begin
        rep_q <= rep_q + DIV_W'(1);
      end
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign cnt_o       = cnt_q;
  assign cur_ratio_o = cur_ratio;
  assign ph_b_o      = (ph_q == PH_B);
endmodule

// File: rtl/frac_div_outgate.sv
module frac_div_outgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_d_i,
  input  logic per_end_i,
  input  logic ogate_i,
  input  logic igate_i,
  input  logic byp_i,
  output logic sq_o,
  output logic act_o,
  output logic clk_o,
  output logic tick_o
);
  logic sq_q, act_q, act_d, tick_q;
  logic bsel_n, ben_n;

  // gate may only move while the next wave value is low
  assign act_d = hi_d_i ? act_q : ogate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q   <= 1'b0;
      act_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      sq_q   <= hi_d_i;
      act_q  <= act_d;
      tick_q <= (per_end_i & act_d) | (byp_i & igate_i & ogate_i);
    end
  end

  // bypass select and enable change only while the reference is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsel_n <= 1'b0;
      ben_n  <= 1'b0;
    end else begin
      bsel_n <= byp_i;
      ben_n  <= byp_i & igate_i & ogate_i;
    end
  end

  assign clk_o  = bsel_n ? (clk_i & ben_n) : (sq_q & act_q);
  assign tick_o = tick_q;
  assign sq_o   = sq_q;
  assign act_o  = act_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              clk_o,
  output logic              tick_o
);
  logic [DIV_W-1:0] ratio_a, ratio_b, reps_a, reps_b, cnt, cur_ratio;
  logic dual, ogate, igate, byp, hi_d, per_end, ph_b, sq, act;

  frac_div_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ratio_a_o(ratio_a), .ratio_b_o(ratio_b),
    .reps_a_o(reps_a), .reps_b_o(reps_b),
    .dual_o(dual), .ogate_o(ogate), .igate_o(igate), .byp_o(byp)
  );

  frac_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i, .rst_ni,
    .ratio_a_i(ratio_a), .ratio_b_i(ratio_b),
    .reps_a_i(reps_a), .reps_b_i(reps_b),
    .dual_i(dual), .igate_i(igate), .byp_i(byp),
    .hi_d_o(hi_d), .per_end_o(per_end),
    .cnt_o(cnt), .cur_ratio_o(cur_ratio), .ph_b_o(ph_b)
  );

  frac_div_outgate u_out (
    .clk_i, .rst_ni,
    .hi_d_i(hi_d), .per_end_i(per_end),
    .ogate_i(ogate), .igate_i(igate), .byp_i(byp),
    .sq_o(sq), .act_o(act), .clk_o, .tick_o
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int unsigned DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             igate,
  input logic             ogate,
  input logic             byp,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] cur_ratio,
  input logic             ph_b,
  input logic             sq,
  input logic             act,
  input logic             tick_o
);
  p_no_tick_igate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!igate && !byp) |=> !tick_o);

  p_restart_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !igate |=> (cnt == '0) && !ph_b);

  p_cnt_recover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt > cur_ratio) |=> (cnt == '0));

  p_gate_at_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act) |-> !sq);

  p_no_tick_ogate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ogate && !byp) |=> !tick_o);

  p_byp_wave_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp |=> !sq);
endmodule

bind frac_clk_div frac_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .igate(igate), .ogate(ogate), .byp(byp),
  .cnt(cnt), .cur_ratio(cur_ratio), .ph_b(ph_b), .sq(sq), .act(act),
  .tick_o(tick_o)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        clk_o, tick_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  frac_clk_div uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .clk_o(clk_o), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_a(int ra, int rb, bit dual, bit og, bit ig);
    return {ig, og, 1'b0, dual, 4'b0, 12'(rb), 12'(ra)};
  endfunction
  function automatic logic [31:0] word_b(int ma, int mb, bit byp);
    return {7'b0, byp, 12'(mb), 12'(ma)};
  endfunction

  task automatic wr(input bit addr, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // scoreboard
  int exp_q[$];
  bit mon_en = 0, have_last = 0;
  longint cyc = 0, last = 0, sum_iv = 0;

  always @(negedge clk) begin
    cyc++;
    if (!mon_en) have_last = 0;
    else if (tick_o) begin
      if (have_last) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected tick", int'(cyc - last), 0);
        else begin
          automatic int e = exp_q.pop_front();
          check(int'(cyc - last) == e, "R4/R5 period", int'(cyc - last), e);
          sum_iv += cyc - last;
        end
      end
      have_last = 1;
      last = cyc;
    end
  end

  // push periods 1..cnt of the pattern (period 0 only arms the monitor)
  task automatic run_seq(input int ra, rb, ma, mb, input bit dual, input int cnt, output longint exp_sum);
    automatic int ph = 0, rep = 0;
    exp_sum = 0;
    for (int i = 0; i <= cnt; i++) begin
      if (i > 0) begin
        exp_q.push_back(ph ? rb + 1 : ra + 1);
        exp_sum += ph ? rb + 1 : ra + 1;
      end
      if (dual) begin
        if (rep == (ph ? mb : ma)) begin rep = 0; ph = 1 - ph; end
        else rep++;
      end
    end
  endtask

  task automatic sb_run(input int ra, rb, ma, mb, input bit dual, input int cnt, input string req);
    longint es;
    wr(1'b0, word_a(ra, rb, dual, 0, 0));
    wr(1'b1, word_b(ma, mb, 0));
    run_seq(ra, rb, ma, mb, dual, cnt, es);
    @(posedge clk); #1;
    sum_iv = 0; mon_en = 1;
    wr(1'b0, word_a(ra, rb, dual, 1, 1));
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    mon_en = 0;
    check(sum_iv == es, req, int'(sum_iv), int'(es));
  endtask

  task automatic duty(input int ra, input string req);
    int hi, lo;
    wr(1'b0, word_a(ra, 0, 0, 1, 1));
    @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    hi = 0; lo = 0;
    while (clk_o === 1'b1) begin hi++; @(negedge clk); end
    while (clk_o === 1'b0) begin lo++; @(negedge clk); end
    check(hi == (ra + 1) / 2, {req, " high"}, hi, (ra + 1) / 2);
    check(lo == (ra + 1) - (ra + 1) / 2, {req, " low"}, lo, (ra + 1) - (ra + 1) / 2);
    wr(1'b0, word_a(ra, 0, 0, 0, 0));
  endtask

  initial begin
    #(PER * 190000);
    check(0, "watchdog", 0, 1);
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nt, nh;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    nt = 0; nh = 0;
    repeat (20) begin @(negedge clk); nt += tick_o; nh += clk_o; end
    check(nt == 0, "R1 tick after reset", nt, 0);
    check(nh == 0, "R1 clk_o after reset", nh, 0);

    // R4, R2: single mode, second ratio and counts ignored
    sb_run(4, 2, 3, 5, 0, 6, "R4 single sum");
    wr(1'b0, word_a(4, 2, 0, 0, 0));
    // R6 odd and even ratios
    duty(4, "R6 ratio5");
    duty(5, "R6 ratio6");

    // R5, R3: dual mode, 2x ratio5 then 3x ratio4
    sb_run(4, 3, 1, 2, 1, 12, "R5 dual sum");
    // R7: close input gate mid-pattern, reopen restarts with first ratio
    repeat (13) @(posedge clk);
    wr(1'b0, word_a(4, 3, 1, 0, 0));
    repeat (5) @(posedge clk);
    sb_run(4, 3, 1, 2, 1, 6, "R7 restart sum");
    wr(1'b0, word_a(4, 3, 1, 0, 0));
    nt = 0;
    repeat (20) begin @(negedge clk); nt += tick_o; end
    check(nt == 0, "R7 no tick with input gate closed", nt, 0);

    // R8: input open, output closed
    wr(1'b0, word_a(4, 0, 0, 0, 1));
    nt = 0; nh = 0;
    repeat (40) begin @(negedge clk); nt += tick_o; nh += clk_o; end
    check(nt == 0, "R8 tick with output gate closed", nt, 0);
    check(nh == 0, "R8 clk_o with output gate closed", nh, 0);
    wr(1'b0, word_a(4, 0, 0, 1, 1));
    @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    nh = 0;
    while (clk_o === 1'b1) begin nh++; @(negedge clk); end
    check(nh == 2, "R8 first pulse full length", nh, 2);
    wr(1'b0, word_a(4, 0, 0, 0, 0));

    // R5 reference setting: pattern sums to 13916
    sb_run(732, 731, 7, 10, 1, 19, "R5 reference sum");
    check(sum_iv == 13916, "R5 reference pattern cycles", int'(sum_iv), 13916);
    wr(1'b0, word_a(732, 731, 1, 0, 0));

    // R9 bypass with odd settings
    wr(1'b1, word_b(9, 9, 1));
    wr(1'b0, word_a(2, 7, 1, 1, 1));
    repeat (3) @(posedge clk);
    nh = 0; nt = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      nh += (clk_o === 1'b1);
      nt += (tick_o === 1'b1);
      #5;
      check(clk_o === 1'b0, "R9 low half follows reference", int'(clk_o), 0);
    end
    check(nh == 5, "R9 high half follows reference", nh, 5);
    check(nt == 5, "R9 tick every cycle", nt, 5);
    wr(1'b0, word_a(2, 7, 1, 0, 1));
    repeat (2) @(posedge clk);
    nh = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      nh += (clk_o === 1'b1);
    end
    check(nh == 0, "R9 closed gate holds low", nh, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule